// File: doc/BRIEF.md
# Shared Envelope Level Generator

This block produces one 3-bit envelope level that two tone channels use at the same time. A prescaler counts system clocks up to a programmed 8-bit period. Each time it wraps, the envelope moves one step. The step follows one of two patterns:

- a falling saw that counts down and then wraps;
- a square that sits at full scale for a fixed number of steps and then at zero for the same number.

The surrounding register logic provides three inputs. The first is an 8-bit mode byte, which holds the pattern select bit and two per-channel apply flags. The second is the 8-bit period byte. The third is a one-cycle restart strobe, which that logic raises when the restart bit of the mode byte is written as 1. On that strobe the envelope returns to its starting point. The block registers the two apply flags and presents them on its outputs, so that each channel's level stage can choose between its own volume and the shared envelope. The period register of the surrounding logic is expected to come out of reset holding 0x10.

Top module: `env_shaper`

## Requirements
- R1: While `rst` is high and in the cycle after, `env_level` is 7 and both `apply_a` and `apply_b` are 0.
- R2: For a period value P of 1 or more, the envelope takes exactly one step every P clocks, with no restart in between.
- R3: A period value of 0 behaves like 1: the envelope steps on every clock.
- R4: When `env_mode` bit 0 is 1 (saw), each step lowers the level by one, and a step from 0 goes to 7.
- R5: When `env_mode` bit 0 is 0 (square), the level changes only on every 8th step since the last restart or reset. At that step a level of 0 becomes 7 and any other level becomes 0.
- R6: A high `restart_pulse` loads level 7 on the next edge and clears both the prescaler and the step counter. The following step then comes exactly P clocks (one clock for P=0) after that edge.
- R7: A change of `env_mode` bit 0 leaves the level as it is. The new pattern governs the next step.
- R8: `apply_a` follows `env_mode` bit 3 and `apply_b` follows `env_mode` bit 4, one clock later. The other mode bits have no effect on them.
- R9: Between steps, and with no restart, `env_level` holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| env_mode | input | 8 | Mode byte: bit 0 pattern (0 square, 1 saw), bit 3 apply to A, bit 4 apply to B |
| env_period | input | 8 | Clocks per envelope step; 0 is treated as 1 |
| restart_pulse | input | 1 | One-cycle strobe that returns the envelope to its start |
| env_level | output | 3 | Shared envelope level, 7 is full scale |
| apply_a | output | 1 | Registered apply flag for channel A |
| apply_b | output | 1 | Registered apply flag for channel B |

## Verification
The assertions check on every cycle that:
- the prescaler either advances by one or wraps to zero;
- the level holds between steps;
- a saw step lowers the level by exactly one;
- a square step that is not the 8th leaves the level alone;
- a restart loads full scale;
- the apply flags track their mode bits one clock late.

Other behaviour is visible only over a run of several steps, so only the bench's scenarios show it. This covers the exact spacing of steps for a given period, the 8-step hold of the square pattern counted from a restart, a pattern switch taking effect at the next step, and the period-0 case. The bench shows these through a cycle model driven by directed and random mode, period and restart sequences.

// File: rtl/env_pkg.sv
package env_pkg;

    localparam int LEVEL_W    = 3;
    localparam int PERIOD_W   = 8;
    localparam int CFG_W      = 8;
    localparam int SQ_HOLD    = 8;

    localparam int CFG_PATTERN_BIT = 0;
    localparam int CFG_APPLY_A_BIT = 3;
    localparam int CFG_APPLY_B_BIT = 4;

    typedef enum logic {
        PAT_SQUARE = 1'b0,
        PAT_SAW    = 1'b1
    } pattern_e;

    typedef struct packed {
        logic     apply_a;
        logic     apply_b;
        pattern_e pattern;
    } env_cfg_t;

    function automatic env_cfg_t decode_cfg(input logic [CFG_W-1:0] raw);
        env_cfg_t c;
        c.apply_a = raw[CFG_APPLY_A_BIT];
        c.apply_b = raw[CFG_APPLY_B_BIT];
        c.pattern = raw[CFG_PATTERN_BIT] ? PAT_SAW : PAT_SQUARE;
        return c;
    endfunction

endpackage

// File: rtl/env_prescaler.sv
module env_prescaler #(
    parameter int PERIOD_W = env_pkg::PERIOD_W
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clear,
    input  logic [PERIOD_W-1:0] period,
    output logic                tick
);
    logic [PERIOD_W-1:0] cnt;
    logic [PERIOD_W-1:0] last;

    // Period 0 is folded onto period 1: terminal count is zero either way.
    always_comb begin
        last = (period == '0) ? '0 : period - PERIOD_W'(1);
        tick = !clear && (cnt >= last);
    end

    always_ff @(posedge clk) begin
        if (rst || clear) begin
            cnt <= '0;
        end else if (tick) begin
            cnt <= '0;
        end else begin
            cnt <= cnt + PERIOD_W'(1);
        end
    end

    // R2: the counter either advances by one or wraps to zero
    assert_count_step_R2: assert property (@(posedge clk) disable iff (rst)
        (!clear && !tick) |=> (cnt == $past(cnt) + PERIOD_W'(1)));

    assert_wrap_R2: assert property (@(posedge clk) disable iff (rst)
        (tick || clear) |=> (cnt == '0));

endmodule

// File: rtl/env_stepper.sv
module env_stepper #(
    parameter int LEVEL_W = env_pkg::LEVEL_W,
    parameter int SQ_HOLD = env_pkg::SQ_HOLD
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               restart,
    input  logic               tick,
    input  env_pkg::pattern_e  pattern,
    output logic [LEVEL_W-1:0] level
);
    import env_pkg::*;

    localparam int                 STEP_W   = (SQ_HOLD > 1) ? $clog2(SQ_HOLD) : 1;
    localparam logic [LEVEL_W-1:0] LVL_MAX  = {LEVEL_W{1'b1}};
    localparam logic [STEP_W-1:0]  STEP_END = STEP_W'(SQ_HOLD - 1);

    logic [STEP_W-1:0]  step_cnt;
    logic [LEVEL_W-1:0] level_nxt;
    logic               hold_done;

    always_comb begin
        hold_done = (step_cnt == STEP_END);
        level_nxt = level;
        unique case (pattern)
            PAT_SAW:    level_nxt = level - LEVEL_W'(1);
            PAT_SQUARE: if (hold_done) level_nxt = (level == '0) ? LVL_MAX : '0;
            default:    level_nxt = level;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst || restart) begin
            level    <= LVL_MAX;
            step_cnt <= '0;
        end else if (tick) begin
            level    <= level_nxt;
            step_cnt <= hold_done ? '0 : step_cnt + STEP_W'(1);
        end
    end

    // R6: restart loads full scale
    assert_restart_full_R6: assert property (@(posedge clk) disable iff (rst)
        restart |=> (level == LVL_MAX));

    // R9: level holds between steps
    assert_hold_R9: assert property (@(posedge clk) disable iff (rst)
        (!tick && !restart) |=> $stable(level));

    // R4: saw steps down by one, wrapping
    assert_saw_step_R4: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart && pattern == PAT_SAW) |=> (level == $past(level) - LEVEL_W'(1)));

    // R5: square level only moves on the last step of the hold
    assert_square_hold_R5: assert property (@(posedge clk) disable iff (rst)
        (tick && !restart && pattern == PAT_SQUARE && !hold_done) |=> $stable(level));

endmodule

// File: rtl/env_shaper.sv
module env_shaper #(
    parameter int LEVEL_W  = env_pkg::LEVEL_W,
    parameter int PERIOD_W = env_pkg::PERIOD_W,
    parameter int CFG_W    = env_pkg::CFG_W,
    parameter int SQ_HOLD  = env_pkg::SQ_HOLD
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [CFG_W-1:0]    env_mode,
    input  logic [PERIOD_W-1:0] env_period,
    input  logic                restart_pulse,
    output logic [LEVEL_W-1:0]  env_level,
    output logic                apply_a,
    output logic                apply_b
);
    import env_pkg::*;

    env_cfg_t cfg;
    logic     step_tick;

    always_comb cfg = decode_cfg(env_mode);

    env_prescaler #(.PERIOD_W(PERIOD_W)) u_prescaler (
        .clk    (clk),
        .rst    (rst),
        .clear  (restart_pulse),
        .period (env_period),
        .tick   (step_tick)
    );

    env_stepper #(.LEVEL_W(LEVEL_W), .SQ_HOLD(SQ_HOLD)) u_stepper (
        .clk     (clk),
        .rst     (rst),
        .restart (restart_pulse),
        .tick    (step_tick),
        .pattern (cfg.pattern),
        .level   (env_level)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            apply_a <= 1'b0;
            apply_b <= 1'b0;
        end else begin
            apply_a <= cfg.apply_a;
            apply_b <= cfg.apply_b;
        end
    end

    // R8: apply flags follow their mode bits one clock late
    assert_apply_R8: assert property (@(posedge clk) disable iff (rst)
        1'b1 |=> (apply_a == $past(env_mode[CFG_APPLY_A_BIT]) &&
                  apply_b == $past(env_mode[CFG_APPLY_B_BIT])));

endmodule

// File: tb/env_shaper_bench.sv
module env_shaper_bench;
    logic       clk = 1'b0;
    logic       rst;
    logic [7:0] env_mode;
    logic [7:0] env_period;
    logic       restart_pulse;
    logic [2:0] env_level;
    logic       apply_a, apply_b;

    int total = 0;
    int bad   = 0;
    string cur_req = "R1";

    always #2.5 clk = ~clk;

    env_shaper u_env_shaper (
        .clk(clk), .rst(rst), .env_mode(env_mode), .env_period(env_period),
        .restart_pulse(restart_pulse), .env_level(env_level),
        .apply_a(apply_a), .apply_b(apply_b)
    );

    // Reference model written from the requirements
    int         m_cnt, m_step;
    logic [2:0] m_lvl;
    logic       m_a, m_b;

    function automatic int term_count(input logic [7:0] p);
        return (p == 0) ? 0 : int'(p) - 1;
    endfunction

    always @(posedge clk) begin
        if (rst) begin
            m_cnt <= 0; m_step <= 0; m_lvl <= 3'd7; m_a <= 0; m_b <= 0;
        end else begin
            m_a <= env_mode[3];
            m_b <= env_mode[4];
            if (restart_pulse) begin
                m_cnt <= 0; m_step <= 0; m_lvl <= 3'd7;
            end else if (m_cnt >= term_count(env_period)) begin
                m_cnt  <= 0;
                m_step <= (m_step == 7) ? 0 : m_step + 1;
                if (env_mode[0]) m_lvl <= m_lvl - 3'd1;
                else if (m_step == 7) m_lvl <= (m_lvl == 0) ? 3'd7 : 3'd0;
            end else begin
                m_cnt <= m_cnt + 1;
            end
        end
    end

    task automatic check(input string req, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d t=%0t", req, act, exp, $time);
        end
    endtask

    // One clock: compare at the falling edge, then keep inputs as set
    task automatic cyc();
        @(negedge clk);
        check({cur_req, " level"}, env_level, m_lvl);
        check("R8 apply", {apply_a, apply_b}, {m_a, m_b});
    endtask

    task automatic run(input int n);
        for (int i = 0; i < n; i++) cyc();
    endtask

    task automatic pulse_restart();
        restart_pulse = 1'b1;
        cyc();
        restart_pulse = 1'b0;
    endtask

    initial begin
        int wd = 0;
        forever begin
            @(posedge clk);
            wd++;
            if (wd > 150000) begin
                bad++; total++;
                $display("FAIL watchdog actual=timeout expected=finish");
                $display("test done: total=%0d bad=%0d", total, bad);
                $finish;
            end
        end
    end

    initial begin
        logic [2:0] prev;
        void'($urandom(32'd20240611));
        rst = 1'b1; env_mode = 8'h18; env_period = 8'h10; restart_pulse = 1'b0;
        repeat (3) @(negedge clk);
        // R1: reset state even with apply bits set on the input
        check("R1 level", env_level, 7);
        check("R1 apply", {apply_a, apply_b}, 0);
        @(negedge clk);
        rst = 1'b0; env_mode = 8'h00;
        cyc();
        check("R1 level after release", env_level, 7);

        // R4 + R2: saw with period 3, direct spacing check
        cur_req = "R4";
        env_mode = 8'h01; env_period = 8'd3;
        pulse_restart();
        cur_req = "R2";
        run(2);
        check("R2 no step before period", env_level, 7);
        cyc();
        check("R2 step after period", env_level, 6);
        cur_req = "R4";
        run(30);

        // R3: period 0 steps every clock
        cur_req = "R3";
        env_period = 8'd0;
        for (int i = 0; i < 10; i++) begin
            prev = env_level;
            cyc();
            check("R3 step each clock", env_level, 3'(prev - 3'd1));
        end

        // R5: square, period 1, 8-step hold
        cur_req = "R5";
        env_mode = 8'h00; env_period = 8'd1;
        pulse_restart();
        run(7);
        check("R5 held full", env_level, 7);
        cyc();
        check("R5 flip to zero", env_level, 0);
        run(7);
        check("R5 held zero", env_level, 0);
        cyc();
        check("R5 flip to full", env_level, 7);
        env_period = 8'd2;
        run(40);

        // R6: restart mid-count, next step exactly P clocks later
        cur_req = "R6";
        env_mode = 8'h01; env_period = 8'd5;
        run(3);
        pulse_restart();
        check("R6 restart level", env_level, 7);
        run(4);
        check("R6 no early step", env_level, 7);
        cyc();
        check("R6 step at period", env_level, 6);

        // R7: switch saw to square keeps level
        cur_req = "R7";
        env_period = 8'd1;
        run(2);
        prev = env_level;
        env_mode = 8'h00;
        cyc();
        check("R7 level kept at switch", env_level, prev);
        run(20);

        // R8: apply flags independent of other bits
        cur_req = "R8";
        env_mode = 8'h08; cyc();
        env_mode = 8'h10; cyc();
        env_mode = 8'hE7; cyc();
        check("R8 other bits ignored", {apply_a, apply_b}, 0);
        env_mode = 8'h18; cyc();

        // Random mix
        cur_req = "R2/R9 random";
        for (int i = 0; i < 3000; i++) begin
            if (($urandom % 64) == 0) env_mode = 8'($urandom);
            if (($urandom % 128) == 0) env_period = 8'($urandom % 6);
            restart_pulse = (($urandom % 40) == 0);
            cyc();
        end
        restart_pulse = 1'b0;
        cyc();

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule